// File: doc/BRIEF.md
# Two-Strike Watchdog Timer

This block is a watchdog for a system-on-chip. Software reaches it through a small register window clocked by the peripheral clock. The timeout counter runs on a separate, free-running oscillator clock. Software first sets a 12-bit period value N. It then turns the watchdog on and must keep writing a service word. One expiry of the period only raises a warning flag and an interrupt line. If the period expires a second time with no service in between, the block drives its reset output. That output stays high until the block itself is reset. Software can also trigger a reset directly through a deliberate fault-injection register. A control bit can instead steer that injection to the warning flag.

Each period unit is 2^UNIT_LOG2 oscillator cycles; the default is 2^20. One expiry therefore takes (N+1)·2^UNIT_LOG2 oscillator cycles. Register writes that affect the counter reach the oscillator domain through toggle synchronisers, so they take effect a few oscillator cycles after the write. The elapsed count and the warning flag come back to the peripheral domain through two-flop synchronisers.

Top module: `wdt_timer`

## Requirements
- R1: After reset, `irq_o` and `wdt_rst_o` are low, and a read of any of the six registers (offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14) returns 0.
- R2: The period register at offset 0x04 stores only write-data bits [31:20] as N. A read returns the written word with bits [19:0] forced to zero.
- R3: Once enabled, the counter expires every (N+1)·2^UNIT_LOG2 oscillator cycles. The first expiry comes no sooner than that many cycles after the enabling write and at most 12 oscillator cycles later. The second expiry follows the first by exactly one period.
- R4: The first expiry with no service sets the warning flag. The flag drives `irq_o` and reads as bit 0 at offset 0x0C.
- R5: An expiry while the warning flag is set asserts `wdt_rst_o`. It stays high until the block reset.
- R6: Writing a word with bit 0 set to offset 0x0C clears the elapsed count and the warning flag. Servicing more often than once per period keeps both outputs low. A write there with bit 0 clear has no effect.
- R7: Writing bit 0 = 1 at offset 0x00 enables the counter. A later write of 0 neither clears the enable (read back as bit 0) nor stops counting.
- R8: While enabled, writes to the period register are ignored. Both the read-back value and the expiry time stay unchanged.
- R9: Offset 0x08 reads the elapsed whole period units in bits [11:0]. Any write to it clears the elapsed count without touching the warning flag.
- R10: With bit 0 of offset 0x10 clear, writing bit 0 = 1 at offset 0x14 asserts `wdt_rst_o` within 12 oscillator cycles. This happens even when the counter is disabled, and the warning flag stays clear.
- R11: With bit 0 of offset 0x10 set, the same write at offset 0x14 leaves `wdt_rst_o` low and sets the warning flag instead.
- R12: Before the enabling write, the counter does not advance. No expiry occurs, however long the wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Peripheral (register) clock |
| prst | input | 1 | Synchronous active-high block reset, peripheral domain; also resynchronised into the oscillator domain |
| oclk | input | 1 | Oscillator clock for the timeout counter |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe; `rdata` is valid the next cycle |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Warning flag, oscillator domain |
| wdt_rst_o | output | 1 | Watchdog reset request, oscillator domain, held until block reset |

## Verification
The assertions check these rules on every clock:
- the reset output never falls, and it rises only from a set warning flag or a forced-reset event;
- a service event leaves a zeroed count and a clear flag;
- the enable never drops;
- the period is frozen while enabled;
- a disabled counter holds zero.

The exact length of a period and the first-expiry window across the clock-domain crossing can only be shown by the bench's scenarios. The same holds for the no-effect writes, the steering of the injection write, and the elapsed-count read-back through the synchronisers.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_PER   = 8'h04;
  localparam logic [7:0] OFS_ELAP  = 8'h08;
  localparam logic [7:0] OFS_KICK  = 8'h0C;
  localparam logic [7:0] OFS_PECTL = 8'h10;
  localparam logic [7:0] OFS_PEFRC = 8'h14;

  // events carried from the register domain to the counter domain
  localparam int EV_EN   = 0;
  localparam int EV_PER  = 1;
  localparam int EV_CLR  = 2;
  localparam int EV_KICK = 3;
  localparam int EV_FRST = 4;
  localparam int EV_FIRQ = 5;
  localparam int EV_NUM  = 6;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_PER,
    SEL_ELAP,
    SEL_KICK,
    SEL_PECTL,
    SEL_PEFRC,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/wdt_pulse_sync.sv
module wdt_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst,
  output logic dst_pulse
);

  logic              tog_q;
  logic [STAGES:0]   sh_q;

  always_ff @(posedge src_clk) begin
    if (src_rst)        tog_q <= 1'b0;
    else if (src_pulse) tog_q <= ~tog_q;
  end

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      sh_q      <= '0;
      dst_pulse <= 1'b0;
    end else begin
      sh_q      <= {sh_q[STAGES-1:0], tog_q};
      dst_pulse <= sh_q[STAGES] ^ sh_q[STAGES-1];
    end
  end

endmodule

// File: rtl/wdt_bit_sync.sv
module wdt_bit_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else begin
      sh_q[0] <= d;
      for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
    end
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs import wdt_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PER_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PER_W-1:0]  units_gray,
  input  logic              irq_flag,
  output logic [DATA_W-1:0] rdata,
  output logic [PER_W-1:0]  per_sh,
  output logic [EV_NUM-1:0] ev
);

  localparam int PER_LSB = DATA_W - PER_W;

  reg_sel_e          sel;
  logic              en_sh;
  logic              pe_ctl;
  logic [PER_W-1:0]  units_bin;
  logic              unused_wdata;

  assign unused_wdata = ^wdata[PER_LSB-1:1];

  always_comb begin
    if      (addr == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFS_PER))   sel = SEL_PER;
    else if (addr == ADDR_W'(OFS_ELAP))  sel = SEL_ELAP;
    else if (addr == ADDR_W'(OFS_KICK))  sel = SEL_KICK;
    else if (addr == ADDR_W'(OFS_PECTL)) sel = SEL_PECTL;
    else if (addr == ADDR_W'(OFS_PEFRC)) sel = SEL_PEFRC;
    else                                 sel = SEL_NONE;
  end

  // gray to binary for the synchronised elapsed count
  always_comb begin
    units_bin[PER_W-1] = units_gray[PER_W-1];
    for (int i = PER_W - 2; i >= 0; i--) units_bin[i] = units_bin[i+1] ^ units_gray[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_sh  <= 1'b0;
      pe_ctl <= 1'b0;
      per_sh <= '0;
      ev     <= '0;
    end else begin
      ev <= '0;
      if (wr_en) begin
        case (sel)
          SEL_CTRL: if (wdata[0] && !en_sh) begin
            en_sh      <= 1'b1;
            ev[EV_EN]  <= 1'b1;
          end
          SEL_PER: if (!en_sh) begin
            per_sh     <= wdata[DATA_W-1:PER_LSB];
            ev[EV_PER] <= 1'b1;
          end
          SEL_ELAP:  ev[EV_CLR] <= 1'b1;
          SEL_KICK:  if (wdata[0]) ev[EV_KICK] <= 1'b1;
          SEL_PECTL: pe_ctl <= wdata[0];
          SEL_PEFRC: if (wdata[0]) begin
            if (pe_ctl) ev[EV_FIRQ] <= 1'b1;
            else        ev[EV_FRST] <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (sel)
        SEL_CTRL:  rdata <= DATA_W'(en_sh);
        SEL_PER:   rdata <= {per_sh, {PER_LSB{1'b0}}};
        SEL_ELAP:  rdata <= DATA_W'(units_bin);
        SEL_KICK:  rdata <= DATA_W'(irq_flag);
        SEL_PECTL: rdata <= DATA_W'(pe_ctl);
        default:   rdata <= '0;
      endcase
    end
  end

  // R8: the stored period cannot move once the enable is set
  assert_period_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    en_sh |=> $stable(per_sh));

  // R7: the enable cannot be withdrawn by a write
  assert_enable_kept_R7: assert property (@(posedge clk) disable iff (rst)
    en_sh |=> en_sh);

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int PER_W     = 12,
  parameter int UNIT_LOG2 = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_en,
  input  logic             ev_per,
  input  logic             ev_clr,
  input  logic             ev_kick,
  input  logic             ev_frst,
  input  logic             ev_firq,
  input  logic [PER_W-1:0] per_in,
  output logic             irq_o,
  output logic             rst_o,
  output logic [PER_W-1:0] units_gray
);

  logic                 en_q;
  logic [PER_W-1:0]     per_q;
  logic [PER_W-1:0]     units_q;
  logic [UNIT_LOG2-1:0] pre_q;
  logic                 unit_done;
  logic                 wrap;

  assign unit_done = &pre_q;
  assign wrap      = en_q && unit_done && (units_q == per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      per_q      <= '0;
      units_q    <= '0;
      pre_q      <= '0;
      irq_o      <= 1'b0;
      rst_o      <= 1'b0;
      units_gray <= '0;
    end else begin
      if (ev_per || ev_en) per_q <= per_in;
      if (ev_en)           en_q  <= 1'b1;

      if (ev_kick || ev_clr) begin
        pre_q   <= '0;
        units_q <= '0;
      end else if (en_q) begin
        pre_q <= pre_q + 1'b1;
        if (unit_done) units_q <= wrap ? '0 : units_q + 1'b1;
      end

      if (ev_kick) begin
        irq_o <= 1'b0;
      end else if (wrap && !ev_clr) begin
        if (irq_o) rst_o <= 1'b1;
        else       irq_o <= 1'b1;
      end
      if (ev_firq) irq_o <= 1'b1;
      if (ev_frst) rst_o <= 1'b1;

      units_gray <= units_q ^ (units_q >> 1);
    end
  end

  // R5: reset request is held
  assert_rst_held_R5: assert property (@(posedge clk) disable iff (rst)
    rst_o |=> rst_o);

  // R5 / R10: reset request rises only after a warning or an injection
  assert_rst_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_o) |-> ($past(irq_o) || $past(ev_frst)));

  // R6: service leaves a zero count and a clear flag
  assert_kick_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_kick && !ev_firq) |=> (units_q == '0 && pre_q == '0 && !irq_o));

  // R7: enable never drops in the counter domain
  assert_core_enable_kept_R7: assert property (@(posedge clk) disable iff (rst)
    en_q |=> en_q);

  // R3: elapsed units never pass the programmed limit
  assert_units_bound_R3: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (units_q <= per_q));

  // R12: nothing counts before the enable arrives
  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (units_q == '0 && pre_q == '0));

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer import wdt_pkg::*; #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int PER_W       = 12,
  parameter int UNIT_LOG2   = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              prst,
  input  logic              oclk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic              wdt_rst_o
);

  logic [SYNC_STAGES-1:0] orst_sh;
  logic                   orst;
  logic [EV_NUM-1:0]      ev_p;
  logic [EV_NUM-1:0]      ev_o;
  logic [PER_W-1:0]       per_sh;
  logic [PER_W-1:0]       units_gray_o;
  logic [PER_W-1:0]       units_gray_p;
  logic                   irq_p;

  // block reset carried into the oscillator domain
  always_ff @(posedge oclk) orst_sh <= {orst_sh[SYNC_STAGES-2:0], prst};
  assign orst = orst_sh[SYNC_STAGES-1];

  wdt_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PER_W  (PER_W)
  ) u_regs (
    .clk        (pclk),
    .rst        (prst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .units_gray (units_gray_p),
    .irq_flag   (irq_p),
    .rdata      (rdata),
    .per_sh     (per_sh),
    .ev         (ev_p)
  );

  for (genvar g = 0; g < EV_NUM; g++) begin : g_ev
    wdt_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .src_clk   (pclk),
      .src_rst   (prst),
      .src_pulse (ev_p[g]),
      .dst_clk   (oclk),
      .dst_rst   (orst),
      .dst_pulse (ev_o[g])
    );
  end

  wdt_core #(
    .PER_W     (PER_W),
    .UNIT_LOG2 (UNIT_LOG2)
  ) u_core (
    .clk        (oclk),
    .rst        (orst),
    .ev_en      (ev_o[EV_EN]),
    .ev_per     (ev_o[EV_PER]),
    .ev_clr     (ev_o[EV_CLR]),
    .ev_kick    (ev_o[EV_KICK]),
    .ev_frst    (ev_o[EV_FRST]),
    .ev_firq    (ev_o[EV_FIRQ]),
    .per_in     (per_sh),
    .irq_o      (irq_o),
    .rst_o      (wdt_rst_o),
    .units_gray (units_gray_o)
  );

  wdt_bit_sync #(
    .W      (PER_W + 1),
    .STAGES (SYNC_STAGES)
  ) u_back (
    .clk (pclk),
    .rst (prst),
    .d   ({units_gray_o, irq_o}),
    .q   ({units_gray_p, irq_p})
  );

endmodule

// File: tb/tb_wdt_timer.sv
`timescale 1ns/1ps
module tb_wdt_timer;

  localparam int UL = 4;
  localparam int UNIT = 1 << UL;
  localparam logic [31:0] A_CTRL = 32'h00, A_PER = 32'h04, A_ELAP = 32'h08,
                          A_KICK = 32'h0C, A_PECTL = 32'h10, A_PEFRC = 32'h14;

  logic        pclk = 1'b0, oclk = 1'b0, prst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, wdt_rst_o;
  int          n_tests = 0, n_fail = 0;

  always #5 pclk = ~pclk;
  always #7 oclk = ~oclk;

  wdt_timer #(.UNIT_LOG2(UL)) dut (
    .pclk(pclk), .prst(prst), .oclk(oclk), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o));

  function automatic int period_of(input int n);
    return (n + 1) * UNIT;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_go(input logic [31:0] a, input logic [31:0] d);
    @(negedge pclk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge pclk); wr_en = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    wr_go(a, d);
    repeat (10) @(negedge pclk);
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge pclk); rd_en = 1'b1; addr = a;
    @(negedge pclk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ocyc(input int n, output bit saw);
    saw = 1'b0;
    repeat (n) begin @(negedge oclk); if (irq_o) saw = 1'b1; end
  endtask

  task automatic wait_irq(input int maxc, output int n);
    n = 0;
    while (!irq_o && n < maxc) begin @(negedge oclk); n++; end
  endtask

  task automatic wait_rst(input int maxc, output int n);
    n = 0;
    while (!wdt_rst_o && n < maxc) begin @(negedge oclk); n++; end
  endtask

  task automatic do_reset();
    @(negedge pclk); prst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    repeat (20) @(negedge pclk);
    prst = 1'b0;
    repeat (10) @(negedge oclk);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, v;
    int n, n1, n2, p, nn;
    bit saw, seen;
    void'($urandom(32'd20240611));

    // R1: reset state
    do_reset();
    chk(irq_o == 1'b0, "R1", "irq after reset", irq_o, 0);
    chk(wdt_rst_o == 1'b0, "R1", "rst after reset", wdt_rst_o, 0);
    for (int i = 0; i < 6; i++) begin
      rd(32'(i * 4), d);
      chk(d == 32'h0, "R1", "register read after reset", d, 0);
    end

    // R2: period field masking, random data
    for (int i = 0; i < 8; i++) begin
      v = $urandom;
      wr(A_PER, v);
      rd(A_PER, d);
      chk(d == (v & 32'hFFF0_0000), "R2", "period read-back", d, v & 32'hFFF0_0000);
    end

    // R12: no counting before enable
    wr(A_PER, 32'h0);
    ocyc(100, saw);
    chk(!saw && !wdt_rst_o, "R12", "no expiry while disabled", {saw, wdt_rst_o}, 0);
    rd(A_ELAP, d);
    chk(d == 0, "R12", "elapsed stays zero while disabled", d, 0);

    // R3 R4 R5: random periods, two expiries
    for (int r = 0; r < 4; r++) begin
      do_reset();
      nn = $urandom_range(0, 3);
      p = period_of(nn);
      wr(A_PER, 32'(nn) << 20);
      wr_go(A_CTRL, 32'h1);
      wait_irq(p + 40, n1);
      chk(n1 >= p && n1 <= p + 12, "R3", "first expiry window", n1, p);
      chk(irq_o == 1'b1 && wdt_rst_o == 1'b0, "R4", "warning on first expiry",
          {irq_o, wdt_rst_o}, 2'b10);
      wait_rst(p + 5, n2);
      chk(n2 == p, "R3", "second expiry spacing", n2, p);
      chk(wdt_rst_o == 1'b1, "R5", "reset on second expiry", wdt_rst_o, 1);
      rd(A_KICK, d);
      chk(d == 32'h1, "R4", "warning flag read-back", d, 1);
      ocyc(50, saw);
      chk(wdt_rst_o == 1'b1, "R5", "reset held", wdt_rst_o, 1);
    end
    do_reset();
    chk(wdt_rst_o == 1'b0 && irq_o == 1'b0, "R5", "reset cleared only by block reset",
        {irq_o, wdt_rst_o}, 0);

    // R6: regular service keeps the outputs low
    do_reset();
    wr(A_PER, 32'h1 << 20);
    wr(A_CTRL, 32'h1);
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      ocyc(12, saw); seen |= saw;
      wr(A_KICK, 32'h1);
    end
    chk(!seen && !wdt_rst_o, "R6", "serviced watchdog quiet", {seen, wdt_rst_o}, 0);
    // R6: service word with bit 0 clear does nothing
    wr_go(A_KICK, 32'hFFFF_FFFE);
    wait_irq(2 * period_of(1) + 20, n);
    chk(irq_o == 1'b1, "R6", "bit0-clear write ignored", irq_o, 1);
    wr(A_KICK, 32'h1);
    chk(irq_o == 1'b0, "R6", "service clears warning", irq_o, 0);
    rd(A_KICK, d);
    chk(d == 32'h0, "R6", "warning read-back after service", d, 0);
    chk(wdt_rst_o == 1'b0, "R6", "no reset after service", wdt_rst_o, 0);

    // R7: enable sticky
    do_reset();
    wr(A_PER, 32'h0);
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, d);
    chk(d == 32'h1, "R7", "enable read-back after write of 0", d, 1);
    ocyc(3 * period_of(0) + 20, saw);
    chk(wdt_rst_o == 1'b1, "R7", "counter kept running", wdt_rst_o, 1);

    // R8: period write while enabled ignored
    do_reset();
    wr(A_PER, 32'h1 << 20);
    wr(A_CTRL, 32'h1);
    wr(A_PER, 32'h7 << 20);
    rd(A_PER, d);
    chk(d == (32'h1 << 20), "R8", "period read-back unchanged", d, 32'h1 << 20);
    wr_go(A_KICK, 32'h1);
    wait_irq(300, n);
    chk(n >= period_of(1) && n <= period_of(1) + 12, "R8", "expiry uses old period",
        n, period_of(1));

    // R9: elapsed read-back and clear
    do_reset();
    wr(A_PER, 32'h3 << 20);
    wr(A_CTRL, 32'h1);
    ocyc(40, saw);
    rd(A_ELAP, d);
    chk(d >= 1 && d <= 3, "R9", "elapsed units in range", d, 2);
    wr(A_ELAP, 32'h0);
    repeat (4) @(negedge pclk);
    rd(A_ELAP, d);
    chk(d == 0, "R9", "elapsed cleared by write", d, 0);
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      wr(A_ELAP, 32'h0);
      ocyc(10, saw); seen |= saw;
    end
    chk(!seen, "R9", "repeated clears prevent expiry", seen, 0);

    // R10: forced reset while disabled
    do_reset();
    wr(A_PECTL, 32'h0);
    wr_go(A_PEFRC, 32'h1);
    wait_rst(30, n);
    chk(wdt_rst_o == 1'b1 && n <= 12, "R10", "forced reset latency", n, 12);
    chk(irq_o == 1'b0, "R10", "no warning on forced reset", irq_o, 0);

    // R11: injection steered to warning
    do_reset();
    wr(A_PECTL, 32'h1);
    wr(A_PEFRC, 32'h1);
    ocyc(20, saw);
    chk(wdt_rst_o == 1'b0, "R11", "no reset when steered", wdt_rst_o, 0);
    chk(irq_o == 1'b1, "R11", "warning set when steered", irq_o, 1);
    rd(A_KICK, d);
    chk(d == 32'h1, "R11", "warning read-back", d, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule